// File: doc/BRIEF.md
# Translation Permission and Fault Classifier

This block sits directly behind a translation lookaside buffer search. For every memory access it receives the virtual address, the kind of access (data read, data write or instruction fetch), the processor privilege bit and, from the search, a hit flag, a multiple-hit flag and the fields of the matched entry. These fields are a 2-bit protection code, a dirty bit, a page-size selector and a physical page number. One cycle later the block returns either a physical address with the granted permission, or exactly one fault status with its exception vector.

Three sources of faults are resolved in a fixed order. First, a user-mode access to the upper half of the address space is trapped, except in a small window that user code may reach. Second, a privileged access to the untranslated window is mapped directly, with no lookup. Third, a lookup result is judged against the entry's protection and dirty bits. The block also tells the lookup, in the same cycle, whether address-space-identifier comparison is needed. Entry storage, the search itself and replacement belong to the neighbouring lookup logic.

Top module: `mmu_perm_check`

## Requirements
- R1: Each cycle with `req_valid` high produces `rsp_valid` high on the next cycle with that request's result, and a cycle with `req_valid` low produces `rsp_valid` low on the next cycle. After reset, `rsp_valid` is low and all response fields are zero.
- R2: `asid_check_en` is high, in the same cycle, whenever `sv_mode` is low or `req_priv` is low, and is low only when both are high.
- R3: On a successful translated access, `rsp_paddr` is `{entry_ppn, 10'b0}` with the in-page bits cleared, ORed with the virtual address bits below the page size. Size codes 0, 1, 2 and 3 select 1 KiB, 4 KiB, 64 KiB and 1 MiB pages.
- R4: A privileged access (`req_priv`=1) with address in [0x80000000, 0xC0000000) ignores the lookup inputs. It returns status OK with `rsp_paddr` equal to the address with its top 3 bits cleared.
- R5: A user-mode access (`req_priv`=0) at or above 0x80000000 and outside [0xE0000000, 0xE4000000] (both ends allowed) is an address error, whatever the lookup reports. Status is 11 (vector 0x0C0) for kind 0 (read), 12 (vector 0x100) for kind 1 (write), and 10 (vector 0x0C0) for kind 2 (fetch). Kind 3 is treated as a read.
- R6: The permission key is {protection[1:0], req_priv}. Keys 0 and 2 deny every access: a write gives status 8 (vector 0x0C0), a read gives status 7 (vector 0x0A0), and a fetch gives status 3 (vector 0x0A0).
- R7: Keys 1, 4 and 5 are read-only: a write gives status 8 (vector 0x0C0), and a read succeeds with `rsp_prot`=2'b01.
- R8: Keys 3, 6 and 7 grant the access: `rsp_prot` is 2'b10 for a write and 2'b01 for a read or fetch. Fetches are granted under every key except 0 and 2.
- R9: A write that the key permits, to an entry whose dirty bit is 0, gives status 9 (vector 0x080) instead of OK.
- R10: For translated addresses, a multiple hit wins over a hit: status 2 for a fetch and 6 for data, both with vector 0x140. With neither flag set, a fetch gives status 1 and a read gives status 4, both with vector 0x040, and a write gives status 5 with vector 0x060.
- R11: Status OK (0) always carries vector 0 and a nonzero `rsp_prot`. Any other status carries a nonzero vector, `rsp_prot`=0 and `rsp_paddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | Processor in privileged mode |
| sv_mode | input | 1 | Single-virtual-space mode |
| tlb_hit | input | 1 | Lookup found one entry |
| tlb_multi | input | 1 | Lookup found several entries |
| entry_pr | input | 2 | Protection code of matched entry |
| entry_dirty | input | 1 | Dirty bit of matched entry |
| entry_size | input | 2 | Page-size selector of matched entry |
| entry_ppn | input | 22 | Physical page number of matched entry |
| asid_check_en | output | 1 | Lookup must compare identifiers |
| rsp_valid | output | 1 | Result strobe |
| rsp_status | output | 4 | Result class, 0 = OK |
| rsp_exc_code | output | 12 | Exception vector, 0 when OK |
| rsp_prot | output | 2 | Granted permission: bit 0 read, bit 1 write |
| rsp_paddr | output | 32 | Physical address |

## Verification
The user-mode region trap and the lookup-based judgement can both apply to one access: a user access above 0x80000000 may arrive with a hit, a multiple hit, or a clean-page write. The bench provokes this with directed and random vectors that pair upper-half user addresses with every lookup outcome. It judges the result by requiring the address-error status and vector, not a protection, miss or initial-write fault. The same approach pits a multiple hit against a hit, and a clean-page write against a read-only key, so that the order of the faults is observed at the ports.

// File: rtl/mmu_perm_pkg.sv
package mmu_perm_pkg;

  localparam int EXC_W = 12;

  typedef enum logic [1:0] {
    KIND_RD = 2'd0,
    KIND_WR = 2'd1,
    KIND_FE = 2'd2,
    KIND_X  = 2'd3
  } acc_kind_e;

  typedef enum logic [3:0] {
    ST_OK       = 4'd0,
    ST_I_MISS   = 4'd1,
    ST_I_MULTI  = 4'd2,
    ST_I_VIOL   = 4'd3,
    ST_D_MISS_R = 4'd4,
    ST_D_MISS_W = 4'd5,
    ST_D_MULTI  = 4'd6,
    ST_VIOL_R   = 4'd7,
    ST_VIOL_W   = 4'd8,
    ST_FIRST_WR = 4'd9,
    ST_AERR_F   = 4'd10,
    ST_AERR_R   = 4'd11,
    ST_AERR_W   = 4'd12
  } mmu_status_e;

  function automatic logic [EXC_W-1:0] exc_of(mmu_status_e s);
    case (s)
      ST_OK:                  return 12'h000;
      ST_I_MISS, ST_D_MISS_R: return 12'h040;
      ST_D_MISS_W:            return 12'h060;
      ST_I_MULTI, ST_D_MULTI: return 12'h140;
      ST_I_VIOL, ST_VIOL_R:   return 12'h0A0;
      ST_VIOL_W:              return 12'h0C0;
      ST_FIRST_WR:            return 12'h080;
      ST_AERR_F, ST_AERR_R:   return 12'h0C0;
      ST_AERR_W:              return 12'h100;
      default:                return 12'h0C0;
    endcase
  endfunction

  // Offset width for each page-size selector value.
  function automatic int offset_bits(int sel);
    case (sel)
      0:       return 10;
      1:       return 12;
      2:       return 16;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/mmu_region_check.sv
module mmu_region_check #(
  parameter int              VA_W      = 32,
  parameter logic [VA_W-1:0] PRIV_BASE = 32'h8000_0000,
  parameter logic [VA_W-1:0] BYP_END   = 32'hC000_0000,
  parameter logic [VA_W-1:0] WIN_LO    = 32'hE000_0000,
  parameter logic [VA_W-1:0] WIN_HI    = 32'hE400_0000
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            priv,
  output logic            user_fault,
  output logic            direct_map
);
  logic upper, in_win, in_byp;

  assign upper  = (vaddr >= PRIV_BASE);
  assign in_win = (vaddr >= WIN_LO) && (vaddr <= WIN_HI);
  assign in_byp = upper && (vaddr < BYP_END);

  assign user_fault = !priv && upper && !in_win;
  assign direct_map = priv && in_byp;
endmodule

// File: rtl/mmu_key_decode.sv
module mmu_key_decode
  import mmu_perm_pkg::*;
(
  input  logic [1:0]  pr,
  input  logic        priv,
  input  logic        is_wr,
  input  logic        is_fe,
  output mmu_status_e key_status,
  output logic [1:0]  key_prot
);
  logic [2:0] key;
  logic       deny, ronly;

  assign key = {pr, priv};

  always_comb begin
    deny  = 1'b0;
    ronly = 1'b0;
    case (key)
      3'd0, 3'd2:       deny  = 1'b1;
      3'd1, 3'd4, 3'd5: ronly = 1'b1;
      default:          ;
    endcase
  end

  always_comb begin
    key_status = ST_OK;
    key_prot   = 2'b01;
    if (is_fe) begin
      if (deny) begin
        key_status = ST_I_VIOL;
        key_prot   = 2'b00;
      end
    end else if (deny) begin
      key_status = is_wr ? ST_VIOL_W : ST_VIOL_R;
      key_prot   = 2'b00;
    end else if (ronly && is_wr) begin
      key_status = ST_VIOL_W;
      key_prot   = 2'b00;
    end else if (is_wr) begin
      key_prot = 2'b10;
    end
  end
endmodule

// File: rtl/mmu_pa_form.sv
module mmu_pa_form #(
  parameter int PA_W      = 32,
  parameter int PPN_SHIFT = 10,
  parameter int SIZE_W    = 2
) (
  input  logic [PA_W-1:0]           vaddr,
  input  logic [PA_W-PPN_SHIFT-1:0] ppn,
  input  logic [SIZE_W-1:0]         size_sel,
  output logic [PA_W-1:0]           paddr
);
  localparam int NSZ = 1 << SIZE_W;

  logic [PA_W-1:0] mask_tab [NSZ];
  logic [PA_W-1:0] base, mask;

  for (genvar g = 0; g < NSZ; g++) begin : g_mask
    localparam int OB = mmu_perm_pkg::offset_bits(g);
    assign mask_tab[g] = (PA_W'(1) << OB) - PA_W'(1);
  end

  assign base  = {ppn, {PPN_SHIFT{1'b0}}};
  assign mask  = mask_tab[size_sel];
  assign paddr = (base & ~mask) | (vaddr & mask);
endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
  import mmu_perm_pkg::*;
#(
  parameter int PA_W      = 32,
  parameter int PPN_SHIFT = 10,
  parameter int SIZE_W    = 2,
  parameter int KEEP_BITS = 29
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [PA_W-1:0]           req_vaddr,
  input  logic [1:0]                req_kind,
  input  logic                      req_priv,
  input  logic                      sv_mode,
  input  logic                      tlb_hit,
  input  logic                      tlb_multi,
  input  logic [1:0]                entry_pr,
  input  logic                      entry_dirty,
  input  logic [SIZE_W-1:0]         entry_size,
  input  logic [PA_W-PPN_SHIFT-1:0] entry_ppn,
  output logic                      asid_check_en,
  output logic                      rsp_valid,
  output logic [3:0]                rsp_status,
  output logic [EXC_W-1:0]          rsp_exc_code,
  output logic [1:0]                rsp_prot,
  output logic [PA_W-1:0]           rsp_paddr
);
  localparam logic [PA_W-1:0] DIRECT_MASK = (PA_W'(1) << KEEP_BITS) - PA_W'(1);

  logic        user_fault, direct_map, is_wr, is_fe;
  mmu_status_e key_status, nxt_status;
  logic [1:0]  key_prot, nxt_prot;
  logic [PA_W-1:0] tlb_pa, nxt_pa;

  assign is_wr = (req_kind == KIND_WR);
  assign is_fe = (req_kind == KIND_FE);

  // Identifier comparison needed unless single-space mode in privileged state.
  assign asid_check_en = !sv_mode || !req_priv;

  mmu_region_check #(.VA_W(PA_W)) u_region (
    .vaddr      (req_vaddr),
    .priv       (req_priv),
    .user_fault (user_fault),
    .direct_map (direct_map)
  );

  mmu_key_decode u_key (
    .pr         (entry_pr),
    .priv       (req_priv),
    .is_wr      (is_wr),
    .is_fe      (is_fe),
    .key_status (key_status),
    .key_prot   (key_prot)
  );

  mmu_pa_form #(.PA_W(PA_W), .PPN_SHIFT(PPN_SHIFT), .SIZE_W(SIZE_W)) u_pa (
    .vaddr    (req_vaddr),
    .ppn      (entry_ppn),
    .size_sel (entry_size),
    .paddr    (tlb_pa)
  );

  // Fault priority: region trap, direct map, multi-hit, miss, key, dirty.
  always_comb begin
    nxt_status = ST_OK;
    nxt_prot   = 2'b00;
    nxt_pa     = '0;
    if (user_fault) begin
      nxt_status = is_wr ? ST_AERR_W : (is_fe ? ST_AERR_F : ST_AERR_R);
    end else if (direct_map) begin
      nxt_pa   = req_vaddr & DIRECT_MASK;
      nxt_prot = is_wr ? 2'b10 : 2'b01;
    end else if (tlb_multi) begin
      nxt_status = is_fe ? ST_I_MULTI : ST_D_MULTI;
    end else if (!tlb_hit) begin
      nxt_status = is_fe ? ST_I_MISS : (is_wr ? ST_D_MISS_W : ST_D_MISS_R);
    end else if (key_status != ST_OK) begin
      nxt_status = key_status;
    end else if (is_wr && !entry_dirty) begin
      nxt_status = ST_FIRST_WR;
    end else begin
      nxt_pa   = tlb_pa;
      nxt_prot = key_prot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_status   <= 4'd0;
      rsp_exc_code <= '0;
      rsp_prot     <= 2'b00;
      rsp_paddr    <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_status   <= req_valid ? nxt_status : 4'd0;
      rsp_exc_code <= req_valid ? exc_of(nxt_status) : '0;
      rsp_prot     <= req_valid ? nxt_prot : 2'b00;
      rsp_paddr    <= req_valid ? nxt_pa : '0;
    end
  end

  assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_ok_clean_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 4'd0) |-> (rsp_exc_code == '0 && rsp_prot != 2'b00));
  assert_fault_zeroed_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != 4'd0) |->
      (rsp_exc_code != '0 && rsp_prot == 2'b00 && rsp_paddr == '0));
  assert_user_trap_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_priv && req_vaddr[PA_W-1] &&
     (req_vaddr < 32'hE000_0000 || req_vaddr > 32'hE400_0000))
    |=> (rsp_status >= 4'd10 && rsp_status <= 4'd12));
  assert_direct_map_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv && req_vaddr[PA_W-1 -: 2] == 2'b10)
    |=> (rsp_status == 4'd0 && rsp_paddr[PA_W-1 -: 3] == 3'b000 &&
         rsp_paddr[KEEP_BITS-1:0] == $past(req_vaddr[KEEP_BITS-1:0])));
endmodule

// File: tb/test_mmu_perm_check.sv
module test_mmu_perm_check;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_priv, sv_mode, tlb_hit, tlb_multi, entry_dirty;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind, entry_pr, entry_size;
  logic [21:0] entry_ppn;
  logic        asid_check_en, rsp_valid;
  logic [3:0]  rsp_status;
  logic [11:0] rsp_exc_code;
  logic [1:0]  rsp_prot;
  logic [31:0] rsp_paddr;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mmu_perm_check i_mmu_perm_check (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_priv(req_priv), .sv_mode(sv_mode),
    .tlb_hit(tlb_hit), .tlb_multi(tlb_multi), .entry_pr(entry_pr),
    .entry_dirty(entry_dirty), .entry_size(entry_size), .entry_ppn(entry_ppn),
    .asid_check_en(asid_check_en), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_exc_code(rsp_exc_code),
    .rsp_prot(rsp_prot), .rsp_paddr(rsp_paddr)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit m_user_trap(logic [31:0] va, logic pv);
    return !pv && va >= 32'h8000_0000 && (va < 32'hE000_0000 || va > 32'hE400_0000);
  endfunction

  function automatic bit m_direct(logic [31:0] va, logic pv);
    return pv && va >= 32'h8000_0000 && va < 32'hC000_0000;
  endfunction

  function automatic logic [3:0] m_status(logic [31:0] va, logic [1:0] k, logic pv,
      logic hit, logic mul, logic [1:0] pr, logic dty);
    bit wr = (k == 2'd1);
    bit fe = (k == 2'd2);
    int key = {pr, pv};
    bit deny = (key == 0 || key == 2);
    bit ro   = (key == 1 || key == 4 || key == 5);
    if (m_user_trap(va, pv)) return wr ? 4'd12 : (fe ? 4'd10 : 4'd11);
    if (m_direct(va, pv)) return 4'd0;
    if (mul) return fe ? 4'd2 : 4'd6;
    if (!hit) return fe ? 4'd1 : (wr ? 4'd5 : 4'd4);
    if (fe) return deny ? 4'd3 : 4'd0;
    if (deny) return wr ? 4'd8 : 4'd7;
    if (ro && wr) return 4'd8;
    if (wr && !dty) return 4'd9;
    return 4'd0;
  endfunction

  function automatic logic [11:0] m_code(logic [3:0] s);
    case (s)
      4'd0: return 12'h000;
      4'd1, 4'd4: return 12'h040;
      4'd5: return 12'h060;
      4'd2, 4'd6: return 12'h140;
      4'd3, 4'd7: return 12'h0A0;
      4'd8: return 12'h0C0;
      4'd9: return 12'h080;
      4'd10, 4'd11: return 12'h0C0;
      default: return 12'h100;
    endcase
  endfunction

  function automatic string m_tag(logic [3:0] s, logic [31:0] va, logic pv, logic [1:0] pr);
    int key = {pr, pv};
    if (s >= 4'd10) return "R5";
    if (m_direct(va, pv)) return "R4";
    if (s == 4'd1 || s == 4'd2 || s == 4'd4 || s == 4'd5 || s == 4'd6) return "R10";
    if (s == 4'd9) return "R9";
    if (key == 0 || key == 2) return "R6";
    if (key == 1 || key == 4 || key == 5) return "R7";
    return "R8";
  endfunction

  task automatic apply(logic [31:0] va, logic [1:0] k, logic pv, logic sv,
      logic hit, logic mul, logic [1:0] pr, logic dty, logic [1:0] sz, logic [21:0] ppn);
    logic [3:0]  es;
    logic [31:0] mask, epa;
    logic [1:0]  eprot;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = k; req_priv = pv; sv_mode = sv;
    tlb_hit = hit; tlb_multi = mul; entry_pr = pr; entry_dirty = dty;
    entry_size = sz; entry_ppn = ppn;
    #1;
    check("R2", "asid_check_en", {31'd0, asid_check_en}, {31'd0, (!sv || !pv)});
    es   = m_status(va, k, pv, hit, mul, pr, dty);
    tag  = m_tag(es, va, pv, pr);
    mask = (sz == 2'd0) ? 32'h3FF : (sz == 2'd1) ? 32'hFFF : (sz == 2'd2) ? 32'hFFFF : 32'hFFFFF;
    if (es != 4'd0) epa = 32'd0;
    else if (m_direct(va, pv)) epa = va & 32'h1FFF_FFFF;
    else epa = ({ppn, 10'd0} & ~mask) | (va & mask);
    eprot = (es != 4'd0) ? 2'b00 : (k == 2'd1 ? 2'b10 : 2'b01);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check(tag, "status", {28'd0, rsp_status}, {28'd0, es});
    check(tag, "exc_code", {20'd0, rsp_exc_code}, {20'd0, m_code(es)});
    check((es == 4'd0) ? "R8" : "R11", "prot", {30'd0, rsp_prot}, {30'd0, eprot});
    check((es == 4'd0 && !m_direct(va, pv)) ? "R3" : "R11", "paddr", rsp_paddr, epa);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R1", "rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_priv = 1'b0;
    sv_mode = 1'b0; tlb_hit = 1'b0; tlb_multi = 1'b0; entry_pr = '0;
    entry_dirty = 1'b0; entry_size = '0; entry_ppn = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset valid", {31'd0, rsp_valid}, 32'd0);
    check("R1", "reset status", {28'd0, rsp_status}, 32'd0);
    check("R1", "reset paddr", rsp_paddr, 32'd0);
    rst = 1'b0;

    // R5 window edges, and trap winning over hit / multi / clean write
    apply(32'hE000_0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 2'd1, 22'h1234);
    apply(32'hE400_0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 2'd1, 22'h1234);
    apply(32'hE400_0001, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 2'd1, 22'h1234);
    apply(32'hDFFF_FFFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 1'b1, 2'd1, 22'h1234);
    apply(32'h8000_0000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 1'b1, 2'd1, 22'h1234);
    apply(32'h7FFF_FFFF, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 2'd0, 22'h3ABCD);
    apply(32'hFFFF_FFFF, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 22'h0);
    // R4 direct-mapped window edges
    apply(32'h8000_0000, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 22'h0);
    apply(32'hBFFF_FFFF, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 22'h0);
    apply(32'hC000_0000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 22'h0);
    // R10 multi wins over hit
    apply(32'h0000_1000, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 1'b1, 2'd0, 22'h5);
    apply(32'h0000_1000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 1'b1, 2'd0, 22'h5);
    idle();
    // R6 R7 R8 R9: every key, every kind, both dirty values
    for (int key = 0; key < 8; key++)
      for (int k = 0; k < 3; k++)
        for (int d = 0; d < 2; d++)
          apply(32'h0012_3456, 2'(k), key[0], 1'b0, 1'b1, 1'b0, key[2:1], d[0],
                2'(key & 3), 22'h2AAAA);
    // R3 every page size
    for (int s = 0; s < 4; s++)
      apply(32'h1357_9BDF, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b1, 2'(s), 22'h3FFFFF);

    void'($urandom(32'd20240607));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] va;
      int pick = $urandom % 4;
      va = $urandom;
      if (pick == 0) va = 32'hE000_0000 + ($urandom % 32'h0400_0002);
      if (($urandom % 8) == 0) idle();
      else apply(va, 2'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'(($urandom % 6) == 0), 2'($urandom), 1'($urandom),
                 2'($urandom), 22'($urandom));
    end
    idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule